// File: doc/BRIEF.md
# Split Instruction/Data Bus Router

This block sits between a processor core and its memory side. The core presents two request ports: one for instruction fetches and one for data loads and stores. Every request is decoded by address and by source, then steered to one of two downstream ports. The first is a code-memory port that serves the low code window. The second is a system port that serves SRAM and peripherals. Inside the block, fetches to the code window travel on an instruction-code path and data accesses to the code window travel on a data-code path. These two paths meet at the single code-memory port. A fetch and a data access that target different downstream ports are forwarded in the same cycle.

When both sources want the same downstream port in one cycle, the data source is served and the fetch waits. Once a downstream request has been presented and stalled, it stays locked in place until it is accepted, so a later data request cannot pull it away. Addresses above the system window map to nothing. Such a request is absorbed by the block and answered with an error response. Each upstream port keeps at most one transaction in flight. Each downstream port remembers the order in which it accepted requests, and uses that order to send every response back to the source that issued it.

Top module: `hv_bus_router`

## Requirements
- R1: While reset is asserted, and after its release with no stimulus, neither downstream request valid and neither upstream response valid is high.
- R2: A request of either source whose address is below 0x20000000 is presented on the code-memory port with address, write flag and write data unchanged; the port's source flag `cm_req_instr` is 1 for a fetch and 0 for a data access.
- R3: A data request with an address from 0x20000000 through 0xDFFFFFFF is presented on the system port with address, write flag and write data unchanged and `sb_req_instr` = 0.
- R4: A fetch with an address from 0x20000000 through 0xDFFFFFFF is presented on the system port with `sb_req_instr` = 1.
- R5: A fetch to the code window and a data request to the system window are both presented and both see ready in the same cycle.
- R6: When both sources target the code window in the same cycle with neither locked in, the data request is presented and gets ready; the fetch sees ready low, and it is presented in a later cycle once the data source is no longer competing.
- R7: When both sources target the system window in the same cycle with neither locked in, the data request is presented and the fetch sees ready low.
- R8: A downstream request that is valid while its ready is low is held, with the same address, source flag and write flag, until it is accepted, even if a higher-priority request arrives meanwhile.
- R9: A request with an address of 0xE0000000 or above is accepted with no downstream request. In the following cycle it receives a response with error flag 1 and data 0, which is held until the response is accepted.
- R10: Each upstream port has at most one outstanding request: its request ready stays low from acceptance until its response handshake. Responses from a downstream port go back, in acceptance order, to the source that issued each request, and the downstream response ready follows that source's response ready.
- R11: Downstream response data and error flag reach the owning upstream port in the same cycle that they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_req_valid | input | 1 | Fetch request valid |
| fe_req_ready | output | 1 | Fetch request accepted |
| fe_req_addr | input | AW | Fetch address |
| fe_rsp_valid | output | 1 | Fetch response valid |
| fe_rsp_ready | input | 1 | Fetch response accepted |
| fe_rsp_data | output | DW | Fetch response data |
| fe_rsp_err | output | 1 | Fetch response error |
| da_req_valid | input | 1 | Data request valid |
| da_req_ready | output | 1 | Data request accepted |
| da_req_addr | input | AW | Data address |
| da_req_write | input | 1 | Data request is a write |
| da_req_wdata | input | DW | Data write value |
| da_rsp_valid | output | 1 | Data response valid |
| da_rsp_ready | input | 1 | Data response accepted |
| da_rsp_data | output | DW | Data response data |
| da_rsp_err | output | 1 | Data response error |
| cm_req_valid | output | 1 | Code-memory request valid |
| cm_req_ready | input | 1 | Code-memory request accepted |
| cm_req_addr | output | AW | Code-memory address |
| cm_req_write | output | 1 | Code-memory write flag |
| cm_req_wdata | output | DW | Code-memory write value |
| cm_req_instr | output | 1 | Code-memory request comes from the fetch source |
| cm_rsp_valid | input | 1 | Code-memory response valid |
| cm_rsp_ready | output | 1 | Code-memory response accepted |
| cm_rsp_data | input | DW | Code-memory response data |
| cm_rsp_err | input | 1 | Code-memory response error |
| sb_req_valid | output | 1 | System request valid |
| sb_req_ready | input | 1 | System request accepted |
| sb_req_addr | output | AW | System address |
| sb_req_write | output | 1 | System write flag |
| sb_req_wdata | output | DW | System write value |
| sb_req_instr | output | 1 | System request comes from the fetch source |
| sb_rsp_valid | input | 1 | System response valid |
| sb_rsp_ready | output | 1 | System response accepted |
| sb_rsp_data | input | DW | System response data |
| sb_rsp_err | input | 1 | System response error |

## Verification
Routing, source priority and upstream ready are combinational. They are therefore checked one time unit after inputs change in the low clock phase, and the valids are withdrawn before the next rising edge so that no transaction is taken. Lock-in, in-flight blocking and response ordering appear in the cycle after the rising edge that accepted a request, so those checks sample after the following falling edge. The error response is due one cycle after its acceptance edge and is sampled again a cycle later to show that it is held. Response data and ready flow back in the same cycle, so they are checked in the same low phase in which the bench drives the downstream response.

// File: rtl/hv_route_pkg.sv
package hv_route_pkg;
  // Source numbering: lower index wins arbitration.
  localparam int NSRC      = 2;
  localparam int SRC_DATA  = 0;
  localparam int SRC_FETCH = 1;
  localparam int SRC_W     = (NSRC > 1) ? $clog2(NSRC) : 1;

  // Downstream port numbering.
  localparam int NPORT     = 2;
  localparam int PORT_CODE = 0;
  localparam int PORT_SYS  = 1;

  typedef logic [SRC_W-1:0] src_id_t;

  typedef enum logic [1:0] {
    DST_CODE = 2'd0,
    DST_SYS  = 2'd1,
    DST_NONE = 2'd2
  } dst_e;
endpackage

// File: rtl/hv_region_decode.sv
module hv_region_decode
  import hv_route_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] CODE_LIMIT = 32'h2000_0000,
  parameter logic [AW-1:0] SYS_LIMIT  = 32'hE000_0000
) (
  input  logic [AW-1:0] addr,
  output dst_e          dst
);
  // Window limits are exclusive upper bounds.
  always_comb begin
    if (addr < CODE_LIMIT) begin
      dst = DST_CODE;
    end else if (addr < SYS_LIMIT) begin
      dst = DST_SYS;
    end else begin
      dst = DST_NONE;
    end
  end
endmodule

// File: rtl/hv_port_arb.sv
module hv_port_arb
  import hv_route_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          want,
  input  logic [NSRC-1:0][AW-1:0]  src_addr,
  input  logic [NSRC-1:0]          src_write,
  input  logic [NSRC-1:0][DW-1:0]  src_wdata,
  output logic [NSRC-1:0]          src_accept,
  input  logic [NSRC-1:0]          src_rsp_ready,
  output logic [NSRC-1:0]          src_rsp_valid,
  output logic                     ds_req_valid,
  input  logic                     ds_req_ready,
  output logic [AW-1:0]            ds_req_addr,
  output logic                     ds_req_write,
  output logic [DW-1:0]            ds_req_wdata,
  output logic                     ds_req_instr,
  input  logic                     ds_rsp_valid,
  output logic                     ds_rsp_ready
);
  localparam int CW = $clog2(NSRC + 1);

  // Grant lock: a stalled downstream request keeps its owner.
  logic    lock_vld_q, lock_vld_d;
  src_id_t lock_id_q;
  logic    lock_id_en;

  // Order tracker: source ids of accepted, unanswered requests.
  logic [CW-1:0]           cnt_q, cnt_d, wr_idx;
  src_id_t [NSRC-1:0]      ids_q, ids_d;
  logic                    ord_en;

  src_id_t pick, win, head;
  logic    fire, push, pop, nonempty;

  // Fixed priority: lowest source index (data) first.
  always_comb begin
    pick = src_id_t'(NSRC - 1);
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (want[s]) pick = src_id_t'(s);
    end
    win = lock_vld_q ? lock_id_q : pick;
  end

  assign ds_req_valid = lock_vld_q | (|want);
  assign ds_req_addr  = src_addr[win];
  assign ds_req_write = src_write[win];
  assign ds_req_wdata = src_wdata[win];
  assign ds_req_instr = (win == src_id_t'(SRC_FETCH));
  assign fire         = ds_req_valid & ds_req_ready;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      src_accept[s] = fire && (win == src_id_t'(s));
    end
  end

  // Lock next state.
  assign lock_vld_d = ds_req_valid & ~ds_req_ready;
  assign lock_id_en = lock_vld_d & ~lock_vld_q;

  // Response return path.
  assign head         = ids_q[0];
  assign nonempty     = (cnt_q != '0);
  assign ds_rsp_ready = nonempty & src_rsp_ready[head];
  assign pop          = ds_rsp_valid & ds_rsp_ready;
  assign push         = fire;
  assign ord_en       = push | pop;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      src_rsp_valid[s] = ds_rsp_valid && nonempty && (head == src_id_t'(s));
    end
  end

  // Order tracker next state.
  always_comb begin
    ids_d = ids_q;
    if (pop) begin
      for (int i = 0; i < NSRC - 1; i++) begin
        ids_d[i] = ids_q[i+1];
      end
    end
    wr_idx = pop ? (cnt_q - CW'(1)) : cnt_q;
    if (push) begin
      ids_d[wr_idx[SRC_W-1:0]] = win;
    end
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_vld_q <= 1'b0;
      lock_id_q  <= '0;
    end else begin
      lock_vld_q <= lock_vld_d;
      if (lock_id_en) begin
        lock_id_q <= win;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ids_q <= '0;
    end else if (ord_en) begin
      cnt_q <= cnt_d;
      ids_q <= ids_d;
    end
  end
endmodule

// File: rtl/hv_bus_router.sv
module hv_bus_router
  import hv_route_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            DW         = 32,
  parameter logic [AW-1:0] CODE_LIMIT = 32'h2000_0000,
  parameter logic [AW-1:0] SYS_LIMIT  = 32'hE000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fe_req_valid,
  output logic          fe_req_ready,
  input  logic [AW-1:0] fe_req_addr,
  output logic          fe_rsp_valid,
  input  logic          fe_rsp_ready,
  output logic [DW-1:0] fe_rsp_data,
  output logic          fe_rsp_err,
  input  logic          da_req_valid,
  output logic          da_req_ready,
  input  logic [AW-1:0] da_req_addr,
  input  logic          da_req_write,
  input  logic [DW-1:0] da_req_wdata,
  output logic          da_rsp_valid,
  input  logic          da_rsp_ready,
  output logic [DW-1:0] da_rsp_data,
  output logic          da_rsp_err,
  output logic          cm_req_valid,
  input  logic          cm_req_ready,
  output logic [AW-1:0] cm_req_addr,
  output logic          cm_req_write,
  output logic [DW-1:0] cm_req_wdata,
  output logic          cm_req_instr,
  input  logic          cm_rsp_valid,
  output logic          cm_rsp_ready,
  input  logic [DW-1:0] cm_rsp_data,
  input  logic          cm_rsp_err,
  output logic          sb_req_valid,
  input  logic          sb_req_ready,
  output logic [AW-1:0] sb_req_addr,
  output logic          sb_req_write,
  output logic [DW-1:0] sb_req_wdata,
  output logic          sb_req_instr,
  input  logic          sb_rsp_valid,
  output logic          sb_rsp_ready,
  input  logic [DW-1:0] sb_rsp_data,
  input  logic          sb_rsp_err
);
  // Upstream view, indexed by source.
  logic [NSRC-1:0]         up_valid, up_write, up_req_ready, up_accept;
  logic [NSRC-1:0][AW-1:0] up_addr;
  logic [NSRC-1:0][DW-1:0] up_wdata;
  logic [NSRC-1:0]         up_rsp_valid, up_rsp_ready, up_rsp_err, up_rsp_fire;
  logic [NSRC-1:0][DW-1:0] up_rsp_data;
  dst_e                    up_dst [NSRC];

  // Downstream view, indexed by port.
  logic [NPORT-1:0]         ds_req_valid, ds_req_ready, ds_req_write, ds_req_instr;
  logic [NPORT-1:0][AW-1:0] ds_req_addr;
  logic [NPORT-1:0][DW-1:0] ds_req_wdata;
  logic [NPORT-1:0]         ds_rsp_valid, ds_rsp_ready, ds_rsp_err;
  logic [NPORT-1:0][DW-1:0] ds_rsp_data;

  logic [NPORT-1:0][NSRC-1:0] want, acc, rspv;

  // Per-source state: one outstanding request, optional local error.
  logic [NSRC-1:0] busy_q, busy_d, err_q, err_d, st_en;

  assign up_valid[SRC_DATA]      = da_req_valid;
  assign up_valid[SRC_FETCH]     = fe_req_valid;
  assign up_addr[SRC_DATA]       = da_req_addr;
  assign up_addr[SRC_FETCH]      = fe_req_addr;
  assign up_write[SRC_DATA]      = da_req_write;
  assign up_write[SRC_FETCH]     = 1'b0;
  assign up_wdata[SRC_DATA]      = da_req_wdata;
  assign up_wdata[SRC_FETCH]     = '0;
  assign up_rsp_ready[SRC_DATA]  = da_rsp_ready;
  assign up_rsp_ready[SRC_FETCH] = fe_rsp_ready;

  assign da_req_ready = up_req_ready[SRC_DATA];
  assign fe_req_ready = up_req_ready[SRC_FETCH];
  assign da_rsp_valid = up_rsp_valid[SRC_DATA];
  assign fe_rsp_valid = up_rsp_valid[SRC_FETCH];
  assign da_rsp_data  = up_rsp_data[SRC_DATA];
  assign fe_rsp_data  = up_rsp_data[SRC_FETCH];
  assign da_rsp_err   = up_rsp_err[SRC_DATA];
  assign fe_rsp_err   = up_rsp_err[SRC_FETCH];

  assign ds_req_ready[PORT_CODE] = cm_req_ready;
  assign ds_req_ready[PORT_SYS]  = sb_req_ready;
  assign ds_rsp_valid[PORT_CODE] = cm_rsp_valid;
  assign ds_rsp_valid[PORT_SYS]  = sb_rsp_valid;
  assign ds_rsp_data[PORT_CODE]  = cm_rsp_data;
  assign ds_rsp_data[PORT_SYS]   = sb_rsp_data;
  assign ds_rsp_err[PORT_CODE]   = cm_rsp_err;
  assign ds_rsp_err[PORT_SYS]    = sb_rsp_err;

  assign cm_req_valid = ds_req_valid[PORT_CODE];
  assign cm_req_addr  = ds_req_addr[PORT_CODE];
  assign cm_req_write = ds_req_write[PORT_CODE];
  assign cm_req_wdata = ds_req_wdata[PORT_CODE];
  assign cm_req_instr = ds_req_instr[PORT_CODE];
  assign cm_rsp_ready = ds_rsp_ready[PORT_CODE];
  assign sb_req_valid = ds_req_valid[PORT_SYS];
  assign sb_req_addr  = ds_req_addr[PORT_SYS];
  assign sb_req_write = ds_req_write[PORT_SYS];
  assign sb_req_wdata = ds_req_wdata[PORT_SYS];
  assign sb_req_instr = ds_req_instr[PORT_SYS];
  assign sb_rsp_ready = ds_rsp_ready[PORT_SYS];

  // One address decoder per source.
  for (genvar s = 0; s < NSRC; s++) begin : g_dec
    hv_region_decode #(
      .AW(AW), .CODE_LIMIT(CODE_LIMIT), .SYS_LIMIT(SYS_LIMIT)
    ) u_dec (
      .addr(up_addr[s]),
      .dst (up_dst[s])
    );
  end

  // Request steering.
  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      for (int s = 0; s < NSRC; s++) begin
        want[k][s] = up_valid[s] && !busy_q[s] &&
                     (up_dst[s] == ((k == PORT_CODE) ? DST_CODE : DST_SYS));
      end
    end
  end

  // One arbiter and order tracker per downstream port.
  for (genvar k = 0; k < NPORT; k++) begin : g_port
    hv_port_arb #(.AW(AW), .DW(DW)) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .want         (want[k]),
      .src_addr     (up_addr),
      .src_write    (up_write),
      .src_wdata    (up_wdata),
      .src_accept   (acc[k]),
      .src_rsp_ready(up_rsp_ready),
      .src_rsp_valid(rspv[k]),
      .ds_req_valid (ds_req_valid[k]),
      .ds_req_ready (ds_req_ready[k]),
      .ds_req_addr  (ds_req_addr[k]),
      .ds_req_write (ds_req_write[k]),
      .ds_req_wdata (ds_req_wdata[k]),
      .ds_req_instr (ds_req_instr[k]),
      .ds_rsp_valid (ds_rsp_valid[k]),
      .ds_rsp_ready (ds_rsp_ready[k])
    );
  end

  // Upstream ready and response merge.
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      up_req_ready[s] = up_valid[s] && !busy_q[s] && (up_dst[s] == DST_NONE);
      up_rsp_valid[s] = err_q[s];
      up_rsp_data[s]  = '0;
      up_rsp_err[s]   = err_q[s];
      for (int k = 0; k < NPORT; k++) begin
        up_req_ready[s] = up_req_ready[s] | acc[k][s];
        if (rspv[k][s] && !err_q[s]) begin
          up_rsp_valid[s] = 1'b1;
          up_rsp_data[s]  = ds_rsp_data[k];
          up_rsp_err[s]   = ds_rsp_err[k];
        end
      end
    end
  end

  assign up_accept   = up_valid & up_req_ready;
  assign up_rsp_fire = up_rsp_valid & up_rsp_ready;

  // Per-source next state.
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      st_en[s]  = up_accept[s] | up_rsp_fire[s];
      busy_d[s] = up_accept[s];
      err_d[s]  = up_accept[s] && (up_dst[s] == DST_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      err_q  <= '0;
    end else begin
      for (int s = 0; s < NSRC; s++) begin
        if (st_en[s]) begin
          busy_q[s] <= busy_d[s];
          err_q[s]  <= err_d[s];
        end
      end
    end
  end
endmodule

// File: rtl/hv_bus_router_chk.sv
module hv_bus_router_chk #(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] CODE_LIMIT = 32'h2000_0000,
  parameter logic [AW-1:0] SYS_LIMIT  = 32'hE000_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fe_req_valid,
  input logic          fe_req_ready,
  input logic [AW-1:0] fe_req_addr,
  input logic          fe_rsp_valid,
  input logic          da_req_valid,
  input logic          da_req_ready,
  input logic [AW-1:0] da_req_addr,
  input logic          da_rsp_valid,
  input logic          da_rsp_err,
  input logic          cm_req_valid,
  input logic          cm_req_ready,
  input logic [AW-1:0] cm_req_addr,
  input logic          cm_req_instr,
  input logic          cm_req_write,
  input logic          cm_rsp_valid,
  input logic          cm_rsp_ready,
  input logic          sb_req_valid,
  input logic          sb_req_ready,
  input logic [AW-1:0] sb_req_addr,
  input logic          sb_req_instr,
  input logic          sb_req_write
);
  logic fe_take_code, da_take_code, fe_take_sys, da_take_sys;
  assign fe_take_code = fe_req_valid && fe_req_ready && (fe_req_addr < CODE_LIMIT);
  assign da_take_code = da_req_valid && da_req_ready && (da_req_addr < CODE_LIMIT);
  assign fe_take_sys  = fe_req_valid && fe_req_ready && (fe_req_addr >= CODE_LIMIT)
                        && (fe_req_addr < SYS_LIMIT);
  assign da_take_sys  = da_req_valid && da_req_ready && (da_req_addr >= CODE_LIMIT)
                        && (da_req_addr < SYS_LIMIT);

  a_r2_code_window: assert property (@(posedge clk) disable iff (!rst_n)
    cm_req_valid |-> (cm_req_addr < CODE_LIMIT));

  a_r3_sys_window: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid |-> ((sb_req_addr >= CODE_LIMIT) && (sb_req_addr < SYS_LIMIT)));

  a_r6_single_code_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(fe_take_code && da_take_code));

  a_r7_single_sys_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(fe_take_sys && da_take_sys));

  a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_req_valid && !cm_req_ready) |=>
      (cm_req_valid && $stable(cm_req_addr) && $stable(cm_req_instr) && $stable(cm_req_write)));

  a_r8_sys_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req_valid && !sb_req_ready) |=>
      (sb_req_valid && $stable(sb_req_addr) && $stable(sb_req_instr) && $stable(sb_req_write)));

  a_r9_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
    (da_req_valid && da_req_ready && (da_req_addr >= SYS_LIMIT)) |=> (da_rsp_valid && da_rsp_err));

  a_r10_da_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    da_rsp_valid |-> !da_req_ready);

  a_r10_fe_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    fe_rsp_valid |-> !fe_req_ready);

  a_r11_code_rsp_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_rsp_valid && cm_rsp_ready) |-> (fe_rsp_valid || da_rsp_valid));
endmodule

bind hv_bus_router hv_bus_router_chk #(
  .AW(AW), .CODE_LIMIT(CODE_LIMIT), .SYS_LIMIT(SYS_LIMIT)
) i_chk (.*);

// File: tb/test_hv_bus_router.sv
module test_hv_bus_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk, rst_n;
  logic          fe_req_valid, fe_req_ready, fe_rsp_valid, fe_rsp_ready, fe_rsp_err;
  logic [AW-1:0] fe_req_addr;
  logic [DW-1:0] fe_rsp_data;
  logic          da_req_valid, da_req_ready, da_req_write, da_rsp_valid, da_rsp_ready, da_rsp_err;
  logic [AW-1:0] da_req_addr;
  logic [DW-1:0] da_req_wdata, da_rsp_data;
  logic          cm_req_valid, cm_req_ready, cm_req_write, cm_req_instr;
  logic          cm_rsp_valid, cm_rsp_ready, cm_rsp_err;
  logic [AW-1:0] cm_req_addr;
  logic [DW-1:0] cm_req_wdata, cm_rsp_data;
  logic          sb_req_valid, sb_req_ready, sb_req_write, sb_req_instr;
  logic          sb_rsp_valid, sb_rsp_ready, sb_rsp_err;
  logic [AW-1:0] sb_req_addr;
  logic [DW-1:0] sb_req_wdata, sb_rsp_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  hv_bus_router i_hv_bus_router (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Routing vectors: inputs, requirement tag, expected outputs.
  typedef struct packed {
    logic          fe_v;
    logic [31:0]   fe_a;
    logic          da_v;
    logic [31:0]   da_a;
    logic [3:0]    req;
    logic          cm_v;
    logic [31:0]   cm_a;
    logic          cm_i;
    logic          sb_v;
    logic [31:0]   sb_a;
    logic          sb_i;
    logic          fe_r;
    logic          da_r;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'h0000_0100, 1'b0, 32'h0, 4'd2,  1'b1, 32'h0000_0100, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0}, // R2 fetch
    '{1'b0, 32'h0, 1'b1, 32'h1FFF_FFFC, 4'd2,  1'b1, 32'h1FFF_FFFC, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R2 data edge
    '{1'b0, 32'h0, 1'b1, 32'h2000_0000, 4'd3,  1'b0, 32'h0, 1'b0, 1'b1, 32'h2000_0000, 1'b0, 1'b0, 1'b1}, // R3 low edge
    '{1'b0, 32'h0, 1'b1, 32'hDFFF_FFFC, 4'd3,  1'b0, 32'h0, 1'b0, 1'b1, 32'hDFFF_FFFC, 1'b0, 1'b0, 1'b1}, // R3 high edge
    '{1'b1, 32'h2000_1000, 1'b0, 32'h0, 4'd4,  1'b0, 32'h0, 1'b0, 1'b1, 32'h2000_1000, 1'b1, 1'b1, 1'b0}, // R4
    '{1'b1, 32'h0000_0040, 1'b1, 32'h4000_0000, 4'd5, 1'b1, 32'h0000_0040, 1'b1, 1'b1, 32'h4000_0000, 1'b0, 1'b1, 1'b1}, // R5
    '{1'b1, 32'h0000_0080, 1'b1, 32'h0000_1000, 4'd6, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R6
    '{1'b1, 32'h2000_0010, 1'b1, 32'h3000_0000, 4'd7, 1'b0, 32'h0, 1'b0, 1'b1, 32'h3000_0000, 1'b0, 1'b0, 1'b1}, // R7
    '{1'b0, 32'h0, 1'b1, 32'hE000_0000, 4'd9,  1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R9
    '{1'b1, 32'hFFFF_FFF0, 1'b1, 32'h0000_0008, 4'd9, 1'b1, 32'h0000_0008, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1}  // R9 mixed
  };

  task automatic chk(input string req, input string what, input logic [69:0] act,
                     input logic [69:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fe_req_valid = 1'b0; fe_req_addr = '0; fe_rsp_ready = 1'b0;
    da_req_valid = 1'b0; da_req_addr = '0; da_req_write = 1'b0; da_req_wdata = '0;
    da_rsp_ready = 1'b0;
    cm_req_ready = 1'b1; cm_rsp_valid = 1'b0; cm_rsp_data = '0; cm_rsp_err = 1'b0;
    sb_req_ready = 1'b1; sb_rsp_valid = 1'b0; sb_rsp_data = '0; sb_rsp_err = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    #3;
    // R1: quiet during reset
    chk("R1", "outputs in reset", 70'({cm_req_valid, sb_req_valid, fe_rsp_valid, da_rsp_valid}), 70'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "outputs after reset", 70'({cm_req_valid, sb_req_valid, fe_rsp_valid, da_rsp_valid}), 70'd0);

    // Routing and priority table; valids withdrawn before each rising edge.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      fe_req_valid = VECS[i].fe_v; fe_req_addr = VECS[i].fe_a;
      da_req_valid = VECS[i].da_v; da_req_addr = VECS[i].da_a;
      #1;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i),
          {cm_req_valid, cm_req_valid ? cm_req_addr : 32'h0, cm_req_valid & cm_req_instr,
           sb_req_valid, sb_req_valid ? sb_req_addr : 32'h0, sb_req_valid & sb_req_instr,
           fe_req_ready, da_req_ready},
          {VECS[i].cm_v, VECS[i].cm_a, VECS[i].cm_i, VECS[i].sb_v, VECS[i].sb_a,
           VECS[i].sb_i, VECS[i].fe_r, VECS[i].da_r});
      #1;
      fe_req_valid = 1'b0; da_req_valid = 1'b0;
    end

    // R3: write attributes pass to the system port.
    @(negedge clk);
    da_req_valid = 1'b1; da_req_addr = 32'h2000_0040; da_req_write = 1'b1;
    da_req_wdata = 32'hCAFE_F00D;
    #1;
    chk("R3", "write passthrough", 70'({sb_req_valid, sb_req_write, sb_req_wdata, sb_req_addr}),
        70'({1'b1, 1'b1, 32'hCAFE_F00D, 32'h2000_0040}));
    #1;
    da_req_valid = 1'b0; da_req_write = 1'b0;

    // Code collision carried through to completion.
    @(negedge clk);
    fe_req_valid = 1'b1; fe_req_addr = 32'h0000_0080;
    da_req_valid = 1'b1; da_req_addr = 32'h0000_1000;
    #1;
    chk("R6", "data wins code port", 70'({fe_req_ready, da_req_ready}), 70'b01);
    @(negedge clk);
    da_req_addr = 32'h2000_0000;
    #1;
    chk("R10", "data blocked while outstanding", 70'({da_req_ready, sb_req_valid}), 70'b00);
    chk("R6", "fetch follows later", 70'({cm_req_valid, cm_req_instr, cm_req_addr}),
        70'({1'b1, 1'b1, 32'h0000_0080}));
    da_req_valid = 1'b0;
    cm_rsp_valid = 1'b1; cm_rsp_data = 32'hDEAD_0001;
    da_rsp_ready = 1'b1; fe_rsp_ready = 1'b1;
    #1;
    chk("R11", "data response same cycle", 70'({da_rsp_valid, da_rsp_data, fe_rsp_valid}),
        70'({1'b1, 32'hDEAD_0001, 1'b0}));
    @(negedge clk);
    fe_req_valid = 1'b0;
    cm_rsp_data = 32'hBEEF_0002; fe_rsp_ready = 1'b0;
    #1;
    chk("R10", "fetch response backpressure", 70'({fe_rsp_valid, fe_rsp_data, cm_rsp_ready, da_rsp_valid}),
        70'({1'b1, 32'hBEEF_0002, 1'b0, 1'b0}));
    @(negedge clk);
    fe_rsp_ready = 1'b1;
    #1;
    chk("R10", "fetch response released", 70'({fe_rsp_valid, cm_rsp_ready}), 70'b11);
    @(negedge clk);
    cm_rsp_valid = 1'b0;
    #1;
    chk("R10", "fetch response retired", 70'({fe_rsp_valid, fe_req_ready}), 70'b00);

    // Stalled downstream request stays locked.
    @(negedge clk);
    cm_req_ready = 1'b0;
    fe_req_valid = 1'b1; fe_req_addr = 32'h0000_0200;
    #1;
    chk("R2", "stalled fetch presented", 70'({cm_req_valid, cm_req_instr, fe_req_ready}), 70'b110);
    @(negedge clk);
    da_req_valid = 1'b1; da_req_addr = 32'h0000_0300; da_req_write = 1'b0;
    #1;
    chk("R8", "lock holds fetch", 70'({cm_req_addr, cm_req_instr, da_req_ready}),
        70'({32'h0000_0200, 1'b1, 1'b0}));
    cm_req_ready = 1'b1;
    #1;
    chk("R8", "locked fetch accepted", 70'({fe_req_ready, da_req_ready}), 70'b10);
    @(negedge clk);
    fe_req_valid = 1'b0;
    #1;
    chk("R8", "data after unlock", 70'({cm_req_addr, cm_req_instr, da_req_ready}),
        70'({32'h0000_0300, 1'b0, 1'b1}));
    @(negedge clk);
    da_req_valid = 1'b0;
    cm_rsp_valid = 1'b1; cm_rsp_data = 32'h0000_0011;
    fe_rsp_ready = 1'b1; da_rsp_ready = 1'b1;
    #1;
    chk("R10", "first response to fetch", 70'({fe_rsp_valid, fe_rsp_data, da_rsp_valid}),
        70'({1'b1, 32'h0000_0011, 1'b0}));
    @(negedge clk);
    cm_rsp_data = 32'h0000_0022;
    #1;
    chk("R10", "second response to data", 70'({da_rsp_valid, da_rsp_data, fe_rsp_valid}),
        70'({1'b1, 32'h0000_0022, 1'b0}));
    @(negedge clk);
    cm_rsp_valid = 1'b0;

    // Unmapped address: local error response.
    @(negedge clk);
    da_req_valid = 1'b1; da_req_addr = 32'hF000_0000; da_req_write = 1'b1;
    da_rsp_ready = 1'b0;
    #1;
    chk("R9", "unmapped accepted locally", 70'({da_req_ready, cm_req_valid, sb_req_valid}), 70'b100);
    @(negedge clk);
    da_req_valid = 1'b0; da_req_write = 1'b0;
    #1;
    chk("R9", "error response", 70'({da_rsp_valid, da_rsp_err, da_rsp_data}),
        70'({1'b1, 1'b1, 32'h0}));
    @(negedge clk);
    #1;
    chk("R9", "error response held", 70'({da_rsp_valid, da_rsp_err}), 70'b11);
    da_rsp_ready = 1'b1;
    @(negedge clk);
    da_req_valid = 1'b1; da_req_addr = 32'h2000_0100;
    #1;
    chk("R9", "error retired, port free", 70'({da_rsp_valid, da_req_ready, sb_req_valid}), 70'b011);
    #1;
    da_req_valid = 1'b0;

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule